// File: doc/BRIEF.md
# Serial receive text line buffer

This block listens to one asynchronous serial line carrying 8N1 frames: a low start bit, eight data bits with the least significant bit first, and a high stop bit. It turns each frame into a byte and keeps the received text in a line of sixteen 8-bit character cells. A display row reads the line through a random-access port. The port takes a character index and returns the stored ASCII code with no clock delay.

The receiver has its own state machine. It times the half period after the start edge and then samples every data bit near its middle. It raises a byte-ready flag once the stop-bit interval has been timed. The flag stays high until the next start bit arrives.

A second state machine watches the flag. It stores a character only after it has seen the flag low and then high again, so one frame yields exactly one store. An ordinary code is written at the write cursor and the cursor then steps forward. A backspace (8) or delete (127) steps the cursor back and writes a space (32) into the cell it now points at. The cursor wraps modulo the line length in both directions.

Top module: `uart_line_buffer`

## Requirements
- R1: After reset every cell reads 0, the write cursor is 0 and `byte_ready` is low.
- R2: The receiver waits half a bit period after the start edge, then samples one bit every BIT_CLKS clocks. It shifts the bits into `rx_data` from the top, so `rx_data` equals the transmitted byte, whose first bit on the line is bit 0.
- R3: `byte_ready` falls in the clock after a low level is seen on an idle line. It rises after the stop-bit interval has been timed, and it stays high while the line stays idle.
- R4: Each frame causes exactly one store, however long `byte_ready` stays high.
- R5: A received code other than 8 or 127 is written into the cell at the cursor, and the cursor then advances by one.
- R6: A received code of 8 or 127 moves the cursor back by one and writes 32 into the cell at the new cursor position.
- R7: The cursor wraps modulo 16. A 17th character overwrites cell 0, and an erase with the cursor at 0 blanks cell 15.
- R8: `rd_char` is a combinational function of `rd_index`: it shows cell `rd_index` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Serial receive line, idle high |
| rd_index | input | 4 | Character cell to read |
| rd_char | output | 8 | ASCII code stored in cell `rd_index` |
| byte_ready | output | 1 | High from the end of a frame until the next start bit |
| rx_data | output | 8 | Last byte received |

## Verification
The bench builds the block with BIT_CLKS set to 12, which makes the half-period wait 6 clocks. A ten-bit frame therefore takes about 120 clocks, so dozens of frames fit in a short run. The line length keeps its default of 16. With that length, typing more than sixteen characters and erasing past cell 0 both come within reach, so the wrap in either direction is exercised. Random printable codes are mixed with both erase codes. After every frame the bench compares all sixteen cells with its own model of the line.

// File: rtl/uart_line_buffer.sv
module uart_line_buffer #(
  parameter int BIT_CLKS = 234,
  parameter int CHARS    = 16,
  parameter int CHAR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_in,
  input  logic [$clog2(CHARS)-1:0]   rd_index,
  output logic [CHAR_W-1:0]          rd_char,
  output logic                       byte_ready,
  output logic [CHAR_W-1:0]          rx_data
);
  localparam int HALF  = BIT_CLKS / 2;
  localparam int CNT_W = $clog2(BIT_CLKS + 1);
  localparam int IDX_W = $clog2(CHARS);
  localparam int BIT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BIT_CLKS - 1);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(CHAR_W - 1);
  localparam logic [CHAR_W-1:0] CODE_BS  = CHAR_W'(8);
  localparam logic [CHAR_W-1:0] CODE_DEL = CHAR_W'(127);
  localparam logic [CHAR_W-1:0] CODE_SP  = CHAR_W'(32);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_WAIT, RX_SAMPLE, RX_STOP} rx_state_t;
  typedef enum logic [1:0] {CAP_LOW, CAP_HIGH, CAP_SAVE} cap_state_t;

  rx_state_t   rx_state;
  cap_state_t  cap_state;
  logic [CNT_W-1:0]        tick;
  logic [BIT_W-1:0]        bit_num;
  logic [IDX_W-1:0]        cursor;
  logic [CHARS*CHAR_W-1:0] line;
  logic                    erase;
  logic [IDX_W-1:0]        back;

  assign erase   = (rx_data == CODE_BS) || (rx_data == CODE_DEL);
  assign back    = cursor - 1'b1;
  assign rd_char = line[rd_index*CHAR_W +: CHAR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_state   <= RX_IDLE;
      tick       <= '0;
      bit_num    <= '0;
      rx_data    <= '0;
      byte_ready <= 1'b0;
    end else begin
      case (rx_state)
        RX_IDLE: if (!rx_in) begin
          rx_state   <= RX_START;
          tick       <= CNT_W'(1);
          bit_num    <= '0;
          byte_ready <= 1'b0;
        end
        RX_START: begin
          if (tick == HALF_C) begin
            rx_state <= RX_WAIT;
            tick     <= CNT_W'(1);
          end else tick <= tick + 1'b1;
        end
        RX_WAIT: begin
          tick <= tick + 1'b1;
          if (tick == LAST_C) rx_state <= RX_SAMPLE;
        end
        RX_SAMPLE: begin
          tick     <= CNT_W'(1);
          rx_data  <= {rx_in, rx_data[CHAR_W-1:1]};
          bit_num  <= bit_num + 1'b1;
          rx_state <= (bit_num == TOP_BIT) ? RX_STOP : RX_WAIT;
        end
        RX_STOP: begin
          tick <= tick + 1'b1;
          if (tick == LAST_C) begin
            rx_state   <= RX_IDLE;
            tick       <= '0;
            byte_ready <= 1'b1;
          end
        end
        default: rx_state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_state <= CAP_LOW;
      cursor    <= '0;
      line      <= '0;
    end else begin
      case (cap_state)
        CAP_LOW:  if (!byte_ready) cap_state <= CAP_HIGH;
        CAP_HIGH: if (byte_ready)  cap_state <= CAP_SAVE;
        CAP_SAVE: begin
          if (erase) begin
            cursor <= back;
            line[back*CHAR_W +: CHAR_W] <= CODE_SP;
          end else begin
            cursor <= cursor + 1'b1;
            line[cursor*CHAR_W +: CHAR_W] <= rx_data;
          end
          cap_state <= CAP_LOW;
        end
        default: cap_state <= CAP_LOW;
      endcase
    end
  end
endmodule

// File: rtl/uart_line_buffer_checks.sv
module uart_line_buffer_checks #(
  parameter int CHARS  = 16,
  parameter int CHAR_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_in,
  input logic                       byte_ready,
  input logic [$clog2(CHARS)-1:0]   cursor,
  input logic [CHARS*CHAR_W-1:0]    line
);
  localparam int IDX_W = $clog2(CHARS);
  logic             ready_d;
  logic [IDX_W-1:0] cursor_d;
  logic             armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_d  <= 1'b0;
      cursor_d <= '0;
      armed    <= 1'b0;
    end else begin
      ready_d  <= byte_ready;
      cursor_d <= cursor;
      if (byte_ready && !ready_d) armed <= 1'b1;
      else if (cursor != cursor_d) armed <= 1'b0;
    end
  end

  assert_ready_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byte_ready) |-> !$past(rx_in));

  assert_one_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cursor != cursor_d) |-> armed);

  assert_cursor_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cursor != $past(cursor)) |->
      (cursor == IDX_W'($past(cursor) + 1'b1)) || (cursor == IDX_W'($past(cursor) - 1'b1)));

  assert_blank_on_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cursor == IDX_W'($past(cursor) - 1'b1)) |-> (line[cursor*CHAR_W +: CHAR_W] == CHAR_W'(32)));
endmodule

bind uart_line_buffer uart_line_buffer_checks #(.CHARS(CHARS), .CHAR_W(CHAR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .byte_ready(byte_ready),
  .cursor(cursor), .line(line)
);

// File: tb/tb_uart_line_buffer.sv
module tb_uart_line_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 12;

  logic clk = 0, rst_n = 0, rx_in = 1;
  logic [3:0] rd_index = 0;
  logic [7:0] rd_char, rx_data;
  logic byte_ready;
  int checks = 0, errors = 0;
  logic [7:0] model [16];
  int cur = 0;
  bit done = 0;

  uart_line_buffer #(.BIT_CLKS(BITC)) dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rd_index(rd_index),
    .rd_char(rd_char), .byte_ready(byte_ready), .rx_data(rx_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_erase(input logic [7:0] c);
    return (c == 8'd8) || (c == 8'd127);
  endfunction

  task automatic model_apply(input logic [7:0] c);
    if (is_erase(c)) begin
      cur = (cur + 15) % 16;
      model[cur] = 8'd32;
    end else begin
      model[cur] = c;
      cur = (cur + 1) % 16;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_line(input string req);
    for (int i = 0; i < 16; i++) begin
      rd_index = 4'(i);
      #1;
      check(req, {24'd0, rd_char}, {24'd0, model[i]});
    end
  endtask

  task automatic send(input logic [7:0] c);
    rx_in = 0;
    wait_clks(3);
    check("R3 ready low after start", {31'd0, byte_ready}, 32'd0);
    wait_clks(BITC - 3);
    for (int b = 0; b < 8; b++) begin
      rx_in = c[b];
      wait_clks(BITC);
    end
    rx_in = 1;
    wait_clks(BITC + 3 * BITC);
    check("R2 rx_data", {24'd0, rx_data}, {24'd0, c});
    check("R3 ready held high", {31'd0, byte_ready}, 32'd1);
    model_apply(c);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) model[i] = 8'd0;
    wait_clks(4);
    rst_n = 1;
    wait_clks(2);
    check("R1 ready after reset", {31'd0, byte_ready}, 32'd0);
    check_line("R1 reset line");

    send(8'd8);
    check_line("R7 erase at column 0 blanks column 15");
    send(8'h41);
    check_line("R5 store at column 15");
    send(8'h42);
    check_line("R7 forward wrap to column 0");
    send(8'd127);
    check_line("R6 delete code erases");
    wait_clks(20 * BITC);
    check_line("R4 idle line adds nothing");
    for (int k = 0; k < 17; k++) send(8'(8'h30 + k));
    check_line("R7 seventeen chars overwrite");
    for (int k = 0; k < 40; k++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) c = 8'd8;
      else if (r == 1) c = 8'd127;
      else c = 8'($urandom_range(32, 126));
      send(c);
      check_line("R5 random traffic");
    end
    send(8'hA5);
    check("R2 pattern A5", {24'd0, rx_data}, 32'hA5);
    for (int i = 15; i >= 0; i--) begin
      rd_index = 4'(i);
      #1;
      check("R8 combinational read", {24'd0, rd_char}, {24'd0, model[i]});
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule